// File: doc/BRIEF.md
# Split-Page Read Dispatcher with Suspendable Program Stream

The dispatcher sits between a translation layer and eight flash channel controllers. A 4 kB logical read arrives as one request that carries a logical page number and a physical block address for each 2 kB half. The low bits of the page number pick one channel pair. The half at the lower address goes to the even channel of the pair and the other half goes to the odd channel, and both commands are issued in the same cycle so the two transfers overlap. Before issue, each half's block address passes through a remap check: a block flagged bad is replaced by its substitute, and a bad block with no substitute ends the request with an error and no channel traffic. Completion is raised only when both halves are back, with the halves placed in address order.

The same block also forwards one program-data job at a time, a fixed number of 2 kB chunks, from a source stream to a media sink stream. When a read is waiting or in flight, the program stream stops at the next chunk boundary and carries on once the read has completed. A byte offset travels with every beat and shows how much of the job went out before the current chunk.

All data interfaces are valid/ready. A transfer takes place on a rising edge where both are high. A sender never withdraws valid and never changes its payload while ready is low. The dispatcher's own ready outputs may drop at any time.

Top module: `sdd_split_dispatch`

## Requirements
- R1: With `req_lpn[1:0]` = p, the even-half command goes out on channel 2p and the odd-half command on channel 2p+1. Each carries its own half's block address, after remapping, on that channel's slice of `ch_cmd_pba`.
- R2: Both channel commands go valid in the cycle after the request is accepted. Each stays valid with a stable address until its own ready is seen, and the two are retired independently.
- R3: `cpl_valid` rises only after both halves have been received, in whichever order they arrive. `cpl_data[DW-1:0]` holds the even channel's word and `cpl_data[2*DW-1:DW]` holds the odd channel's word.
- R4: A half whose block is not flagged in `bad_map` keeps its address. A flagged block takes `rm_to` of the lowest-index entry whose `rm_valid` is set and whose `rm_from` equals it.
- R5: If either half hits a flagged block that has no valid entry, no channel command is issued. Completion follows with `cpl_err`=1 and `cpl_data`=0.
- R6: Only one read is handled at a time. `req_ready` is low from acceptance until the completion handshake, and the completion outputs hold steady while `cpl_ready` is low.
- R7: A `pg_start` pulse while idle begins a job of CHUNKS×CHUNK_BEATS beats, passed through in order with none lost or repeated. `pd_last` is set on the final beat, and a `pg_start` during a job has no effect.
- R8: While a read is waiting (`req_valid`) or in flight, the program stream pauses only at a chunk boundary. Beats inside a started chunk still flow, and the stream resumes after the completion handshake.
- R9: `pd_offset` equals the chunk index times CHUNK_BYTES, that is, the number of bytes sent before the current chunk.
- R10: After reset `req_ready`=1, `pg_active`=0, and `ch_cmd_valid`, `cpl_valid` and `pd_valid` are all 0.
- R11: `ch_rd_ready` is high only on the two channels of the current read whose commands were taken and whose data is still due. Data offered on any other channel is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Dispatcher can take a read |
| req_lpn | input | LPN_W | Logical page number; low bits pick the channel pair |
| req_pba_even | input | PBA_W | Block address of the even (lower) half |
| req_pba_odd | input | PBA_W | Block address of the odd (upper) half |
| bad_map | input | 2^PBA_W | Bit b set means block b is bad |
| rm_valid | input | RM_N | Remap entry valid flags |
| rm_from | input | RM_N*PBA_W | Bad block of each entry |
| rm_to | input | RM_N*PBA_W | Substitute block of each entry |
| ch_cmd_valid | output | NCH | Per-channel command valid |
| ch_cmd_ready | input | NCH | Per-channel command ready |
| ch_cmd_pba | output | NCH*PBA_W | Per-channel command block address |
| ch_rd_valid | input | NCH | Per-channel half-page data valid |
| ch_rd_ready | output | NCH | Per-channel half-page data ready |
| ch_rd_data | input | NCH*DW | Per-channel half-page data word |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion ready |
| cpl_lpn | output | LPN_W | Page number of the completed read |
| cpl_data | output | 2*DW | Halves in address order |
| cpl_err | output | 1 | Unrepairable bad block |
| pg_start | input | 1 | Start a program-data job |
| pg_active | output | 1 | Program job in progress |
| pi_valid | input | 1 | Program source valid |
| pi_ready | output | 1 | Program source ready |
| pi_data | input | PD_W | Program source beat |
| pd_valid | output | 1 | Program sink valid |
| pd_ready | input | 1 | Program sink ready |
| pd_data | output | PD_W | Program sink beat |
| pd_last | output | 1 | Final beat of the job |
| pd_offset | output | OFF_W | Bytes sent before the current chunk |

## Verification
Directed reads cover the lowest and highest channel pair, both arrival orders of the halves, and a bad block that two remap entries claim, where only the lower entry may win. Directed reads also put an unrepairable block on the even half and on the odd half, and each of these must give an error with no command at all. Random reads draw page numbers and addresses from a mix of clean, remappable and unrepairable blocks, so that both the pair decoding and the remap decisions are checked against a bench model. These reads overlap a program job whose sink stalls at random, and every beat's data, offset and last flag is compared with a running count. A beat that starts a chunk while a read is pending counts as a failure, and beats inside a chunk during a read must still occur, which separates pausing at a boundary from stalling anywhere.

// File: rtl/sdd_pkg.sv
package sdd_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_BUSY = 2'd1,
    RD_DONE = 2'd2
  } rd_state_e;
endpackage

// File: rtl/sdd_remap_check.sv
module sdd_remap_check #(
  parameter int PBA_W = 6,
  parameter int RM_N  = 4,
  localparam int NBLK = 1 << PBA_W
) (
  input  logic [PBA_W-1:0]      pba_in,
  input  logic [NBLK-1:0]       bad_map,
  input  logic [RM_N-1:0]       rm_valid,
  input  logic [RM_N*PBA_W-1:0] rm_from,
  input  logic [RM_N*PBA_W-1:0] rm_to,
  output logic [PBA_W-1:0]      pba_out,
  output logic                  miss
);
  logic             hit;
  logic [PBA_W-1:0] sub;
  logic             is_bad;

  // scan from the top so the lowest matching entry is the one kept
  always_comb begin
    hit = 1'b0;
    sub = '0;
    for (int i = RM_N - 1; i >= 0; i--) begin
      if (rm_valid[i] && rm_from[i*PBA_W +: PBA_W] == pba_in) begin
        hit = 1'b1;
        sub = rm_to[i*PBA_W +: PBA_W];
      end
    end
  end

  assign is_bad  = bad_map[pba_in];
  assign pba_out = is_bad ? sub : pba_in;
  assign miss    = is_bad & ~hit;
endmodule

// File: rtl/sdd_prog_dma.sv
module sdd_prog_dma #(
  parameter int PD_W        = 32,
  parameter int CHUNK_BEATS = 4,
  parameter int CHUNKS      = 8,
  parameter int CHUNK_BYTES = 2048,
  parameter int OFF_W       = 16,
  localparam int BEAT_W     = (CHUNK_BEATS > 1) ? $clog2(CHUNK_BEATS) : 1,
  localparam int CHK_W      = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pg_start,
  input  logic             rd_pending,
  output logic             pg_active,
  input  logic             pi_valid,
  output logic             pi_ready,
  input  logic [PD_W-1:0]  pi_data,
  output logic             pd_valid,
  input  logic             pd_ready,
  output logic [PD_W-1:0]  pd_data,
  output logic             pd_last,
  output logic [OFF_W-1:0] pd_offset
);
  logic              active;
  logic [BEAT_W-1:0] beat;
  logic [CHK_W-1:0]  chunk;
  logic              hold;
  logic              flow;
  logic              end_chunk;
  logic              fire;

  assign hold      = (beat == '0) && rd_pending;
  assign flow      = active && !hold;
  assign pd_valid  = flow && pi_valid;
  assign pi_ready  = flow && pd_ready;
  assign pd_data   = pi_data;
  assign end_chunk = (beat == BEAT_W'(CHUNK_BEATS - 1));
  assign pd_last   = end_chunk && (chunk == CHK_W'(CHUNKS - 1));
  assign pd_offset = OFF_W'(chunk) * OFF_W'(CHUNK_BYTES);
  assign pg_active = active;
  assign fire      = pd_valid && pd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      beat   <= '0;
      chunk  <= '0;
    end else if (!active) begin
      if (pg_start) begin
        active <= 1'b1;
        beat   <= '0;
        chunk  <= '0;
      end
    end else if (fire) begin
      if (end_chunk) begin
        beat <= '0;
        if (pd_last) active <= 1'b0;
        else         chunk  <= chunk + 1'b1;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end

  // R9: the offset advances by one chunk after a chunk's final beat
  a_r9_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    fire && end_chunk && !pd_last |=> pd_offset == $past(pd_offset) + OFF_W'(CHUNK_BYTES));
  a_r9_offset_stable: assert property (@(posedge clk) disable iff (!rst_n)
    pd_valid && !pd_ready |=> $stable(pd_offset));
  // R7: the final beat ends the job
  a_r7_last_ends_job: assert property (@(posedge clk) disable iff (!rst_n)
    fire && pd_last |=> !pg_active);
  // R8: a pending read stops the stream only once the chunk is finished
  a_r8_hold_after_chunk: assert property (@(posedge clk) disable iff (!rst_n)
    fire && end_chunk && rd_pending |=> !pd_valid);
endmodule

// File: rtl/sdd_split_dispatch.sv
module sdd_split_dispatch
  import sdd_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int LPN_W       = 16,
  parameter int PBA_W       = 6,
  parameter int RM_N        = 4,
  parameter int DW          = 32,
  parameter int PD_W        = 32,
  parameter int CHUNK_BEATS = 4,
  parameter int CHUNKS      = 8,
  parameter int CHUNK_BYTES = 2048,
  parameter int OFF_W       = 16,
  localparam int NBLK       = 1 << PBA_W,
  localparam int CH_W       = $clog2(NCH),
  localparam int PAIR_W     = CH_W - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [LPN_W-1:0]      req_lpn,
  input  logic [PBA_W-1:0]      req_pba_even,
  input  logic [PBA_W-1:0]      req_pba_odd,
  input  logic [NBLK-1:0]       bad_map,
  input  logic [RM_N-1:0]       rm_valid,
  input  logic [RM_N*PBA_W-1:0] rm_from,
  input  logic [RM_N*PBA_W-1:0] rm_to,
  output logic [NCH-1:0]        ch_cmd_valid,
  input  logic [NCH-1:0]        ch_cmd_ready,
  output logic [NCH*PBA_W-1:0]  ch_cmd_pba,
  input  logic [NCH-1:0]        ch_rd_valid,
  output logic [NCH-1:0]        ch_rd_ready,
  input  logic [NCH*DW-1:0]     ch_rd_data,
  output logic                  cpl_valid,
  input  logic                  cpl_ready,
  output logic [LPN_W-1:0]      cpl_lpn,
  output logic [2*DW-1:0]       cpl_data,
  output logic                  cpl_err,
  input  logic                  pg_start,
  output logic                  pg_active,
  input  logic                  pi_valid,
  output logic                  pi_ready,
  input  logic [PD_W-1:0]       pi_data,
  output logic                  pd_valid,
  input  logic                  pd_ready,
  output logic [PD_W-1:0]       pd_data,
  output logic                  pd_last,
  output logic [OFF_W-1:0]      pd_offset
);
  rd_state_e        state;
  logic [LPN_W-1:0] lpn_q;
  logic [PBA_W-1:0] pba_e_q, pba_o_q;
  logic [CH_W-1:0]  ev_q, od_q;
  logic [1:0]       cmd_pend, got, got_n;
  logic [DW-1:0]    tok_e, tok_o;
  logic             err_q;
  logic             busy;
  logic [PBA_W-1:0] rm_e_pba, rm_o_pba;
  logic             rm_e_miss, rm_o_miss;
  logic             ev_cmd_fire, od_cmd_fire, ev_fire, od_fire;

  sdd_remap_check #(.PBA_W(PBA_W), .RM_N(RM_N)) u_rm_even (
    .pba_in(req_pba_even), .bad_map(bad_map), .rm_valid(rm_valid),
    .rm_from(rm_from), .rm_to(rm_to), .pba_out(rm_e_pba), .miss(rm_e_miss));
  sdd_remap_check #(.PBA_W(PBA_W), .RM_N(RM_N)) u_rm_odd (
    .pba_in(req_pba_odd), .bad_map(bad_map), .rm_valid(rm_valid),
    .rm_from(rm_from), .rm_to(rm_to), .pba_out(rm_o_pba), .miss(rm_o_miss));

  assign busy      = (state == RD_BUSY);
  assign od_q      = {ev_q[CH_W-1:1], 1'b1};
  assign req_ready = (state == RD_IDLE);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic is_ev, is_od;
    assign is_ev = (ev_q == CH_W'(i));
    assign is_od = (od_q == CH_W'(i));
    assign ch_cmd_valid[i] = busy && ((is_ev && cmd_pend[0]) || (is_od && cmd_pend[1]));
    assign ch_cmd_pba[i*PBA_W +: PBA_W] = is_ev ? pba_e_q : (is_od ? pba_o_q : '0);
    assign ch_rd_ready[i] = busy && ((is_ev && !cmd_pend[0] && !got[0]) ||
                                     (is_od && !cmd_pend[1] && !got[1]));
    // R2: an unanswered command keeps its valid and address
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ch_cmd_valid[i] && !ch_cmd_ready[i] |=>
        ch_cmd_valid[i] && $stable(ch_cmd_pba[i*PBA_W +: PBA_W]));
  end

  assign ev_cmd_fire = ch_cmd_valid[ev_q] && ch_cmd_ready[ev_q];
  assign od_cmd_fire = ch_cmd_valid[od_q] && ch_cmd_ready[od_q];
  assign ev_fire     = ch_rd_valid[ev_q] && ch_rd_ready[ev_q];
  assign od_fire     = ch_rd_valid[od_q] && ch_rd_ready[od_q];
  assign got_n       = got | {od_fire, ev_fire};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RD_IDLE;
      lpn_q    <= '0;
      pba_e_q  <= '0;
      pba_o_q  <= '0;
      ev_q     <= '0;
      cmd_pend <= '0;
      got      <= '0;
      tok_e    <= '0;
      tok_o    <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state)
        RD_IDLE: if (req_valid) begin
          lpn_q   <= req_lpn;
          pba_e_q <= rm_e_pba;
          pba_o_q <= rm_o_pba;
          ev_q    <= {req_lpn[PAIR_W-1:0], 1'b0};
          got     <= '0;
          tok_e   <= '0;
          tok_o   <= '0;
          if (rm_e_miss || rm_o_miss) begin
            err_q    <= 1'b1;
            cmd_pend <= '0;
            state    <= RD_DONE;
          end else begin
            err_q    <= 1'b0;
            cmd_pend <= 2'b11;
            state    <= RD_BUSY;
          end
        end
        RD_BUSY: begin
          if (ev_cmd_fire) cmd_pend[0] <= 1'b0;
          if (od_cmd_fire) cmd_pend[1] <= 1'b0;
          if (ev_fire) tok_e <= ch_rd_data[ev_q*DW +: DW];
          if (od_fire) tok_o <= ch_rd_data[od_q*DW +: DW];
          got <= got_n;
          if (got_n == 2'b11) state <= RD_DONE;
        end
        RD_DONE: if (cpl_ready) state <= RD_IDLE;
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign cpl_valid = (state == RD_DONE);
  assign cpl_lpn   = lpn_q;
  assign cpl_data  = {tok_o, tok_e};
  assign cpl_err   = err_q;

  sdd_prog_dma #(
    .PD_W(PD_W), .CHUNK_BEATS(CHUNK_BEATS), .CHUNKS(CHUNKS),
    .CHUNK_BYTES(CHUNK_BYTES), .OFF_W(OFF_W)
  ) u_prog (
    .clk(clk), .rst_n(rst_n), .pg_start(pg_start),
    .rd_pending(req_valid || (state != RD_IDLE)), .pg_active(pg_active),
    .pi_valid(pi_valid), .pi_ready(pi_ready), .pi_data(pi_data),
    .pd_valid(pd_valid), .pd_ready(pd_ready), .pd_data(pd_data),
    .pd_last(pd_last), .pd_offset(pd_offset));

  // R6: completion holds until taken, and no new read overlaps it
  a_r6_cpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && !cpl_ready |=> cpl_valid && $stable(cpl_data) && $stable(cpl_err) && $stable(cpl_lpn));
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !req_ready);
  // R5: an error completion never comes with channel traffic
  a_r5_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_err |-> ch_cmd_valid == '0 && ch_rd_ready == '0);
  // R11: data is taken on at most the two channels of the pair
  a_r11_rd_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ch_rd_ready) <= 2);
  // R3: completion only follows a busy read or an accepted error request
  a_r3_cpl_after_both: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpl_valid) && !cpl_err |-> $past(busy));
endmodule

// File: tb/sdd_split_dispatch_bench.sv
module sdd_split_dispatch_bench;
  localparam int NCH = 8, LPN_W = 16, PBA_W = 6, RM_N = 4, DW = 32, PD_W = 32;
  localparam int CB = 4, CHUNKS = 8, CBYTES = 2048, OFF_W = 16;
  localparam int TOTAL = CB * CHUNKS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic                  req_valid = 1'b0;
  logic                  req_ready;
  logic [LPN_W-1:0]      req_lpn = '0;
  logic [PBA_W-1:0]      req_pba_even = '0, req_pba_odd = '0;
  logic [63:0]           bad_map = '0;
  logic [RM_N-1:0]       rm_valid = '0;
  logic [RM_N*PBA_W-1:0] rm_from = '0, rm_to = '0;
  logic [NCH-1:0]        ch_cmd_valid;
  logic [NCH-1:0]        ch_cmd_ready = '0;
  logic [NCH*PBA_W-1:0]  ch_cmd_pba;
  logic [NCH-1:0]        ch_rd_valid = '0;
  logic [NCH-1:0]        ch_rd_ready;
  logic [NCH*DW-1:0]     ch_rd_data = '0;
  logic                  cpl_valid;
  logic                  cpl_ready = 1'b0;
  logic [LPN_W-1:0]      cpl_lpn;
  logic [2*DW-1:0]       cpl_data;
  logic                  cpl_err;
  logic                  pg_start = 1'b0;
  logic                  pg_active;
  logic                  pi_valid = 1'b0;
  logic                  pi_ready;
  logic [PD_W-1:0]       pi_data = '0;
  logic                  pd_valid;
  logic                  pd_ready = 1'b0;
  logic [PD_W-1:0]       pd_data;
  logic                  pd_last;
  logic [OFF_W-1:0]      pd_offset;

  sdd_split_dispatch u_sdd_split_dispatch (.*);

  int  n_chk = 0, n_err = 0;
  bit  rd_pend_tb = 1'b0;
  int  midpend = 0, jobs_done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] model_remap(input logic [5:0] p);
    if (!bad_map[p]) return {1'b0, p};
    for (int i = 0; i < RM_N; i++)
      if (rm_valid[i] && rm_from[i*PBA_W +: PBA_W] == p) return {1'b0, rm_to[i*PBA_W +: PBA_W]};
    return 7'h40;
  endfunction

  function automatic logic [31:0] tok(input int c, input logic [5:0] p, input logic [15:0] l);
    return {5'h15, 3'(c), 2'b00, p, l};
  endfunction

  function automatic logic [5:0] pick_pba();
    int r = $urandom % 8;
    if (r == 0) return 6'd5;
    if (r == 1) return 6'd9;
    if (r == 2) return 6'd20;
    return 6'($urandom % 64);
  endfunction

  task automatic do_read(input logic [15:0] lpn, input logic [5:0] pe, input logic [5:0] po,
                         input bit odd_first);
    int ev = {lpn[1:0], 1'b0};
    int od = ev + 1;
    logic [6:0] re = model_remap(pe);
    logic [6:0] ro = model_remap(po);
    bit err = re[6] | ro[6];
    int first = odd_first ? od : ev;
    int second = odd_first ? ev : od;
    int stray = (od + 1) % NCH;
    logic [63:0] exp_data = err ? 64'd0 : {tok(od, ro[5:0], lpn), tok(ev, re[5:0], lpn)};
    @(negedge clk);
    req_valid = 1'b1; req_lpn = lpn; req_pba_even = pe; req_pba_odd = po; rd_pend_tb = 1'b1;
    #1 chk("R6 req_ready while idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (err) begin
      chk("R5 no commands on error", ch_cmd_valid, 0);
      chk("R5 error completion valid", cpl_valid, 1);
    end else begin
      chk("R1 R2 both commands on the pair", ch_cmd_valid, (64'd1 << ev) | (64'd1 << od));
      chk("R1 R4 even half address", ch_cmd_pba[ev*PBA_W +: PBA_W], re[5:0]);
      chk("R1 R4 odd half address", ch_cmd_pba[od*PBA_W +: PBA_W], ro[5:0]);
      @(negedge clk);
      #1 chk("R2 commands held without ready", ch_cmd_valid, (64'd1 << ev) | (64'd1 << od));
      @(negedge clk); ch_cmd_ready = NCH'(1 << ev);
      @(negedge clk); ch_cmd_ready = '0;
      #1 chk("R2 even retired alone", ch_cmd_valid, 64'd1 << od);
      @(negedge clk); ch_cmd_ready = NCH'(1 << od);
      @(negedge clk); ch_cmd_ready = '0;
      #1 chk("R2 both retired", ch_cmd_valid, 0);
      @(negedge clk);
      ch_rd_valid = NCH'((1 << first) | (1 << stray));
      ch_rd_data[first*DW +: DW] = (first == ev) ? tok(ev, re[5:0], lpn) : tok(od, ro[5:0], lpn);
      ch_rd_data[stray*DW +: DW] = 32'hDEAD_BEEF;
      #1 chk("R11 stray channel not ready", ch_rd_ready[stray], 0);
      chk("R11 first half ready", ch_rd_ready[first], 1);
      @(negedge clk); ch_rd_valid = '0;
      #1 chk("R3 no completion after one half", cpl_valid, 0);
      @(negedge clk);
      ch_rd_valid = NCH'(1 << second);
      ch_rd_data[second*DW +: DW] = (second == ev) ? tok(ev, re[5:0], lpn) : tok(od, ro[5:0], lpn);
      @(negedge clk); ch_rd_valid = '0;
      #1 chk("R3 completion after both halves", cpl_valid, 1);
    end
    chk("R3 R5 halves in address order", cpl_data, exp_data);
    chk("R5 error flag", cpl_err, err);
    chk("R6 completion page", cpl_lpn, lpn);
    @(negedge clk);
    #1 chk("R6 completion held", {cpl_valid, cpl_data}, {1'b1, exp_data});
    chk("R6 no new read during completion", req_ready, 0);
    @(negedge clk); cpl_ready = 1'b1;
    @(negedge clk); cpl_ready = 1'b0; rd_pend_tb = 1'b0;
    #1 chk("R6 idle after handshake", {cpl_valid, req_ready}, 2'b01);
  endtask

  // program source and sink
  initial begin
    int  jb = 0;
    int  pd_exp = 0;
    bit  took = 1'b0;
    forever begin
      @(negedge clk);
      if (took) pi_data = pi_data + 1;
      took = 1'b0;
      pd_ready = ($urandom % 4) != 0;
      #1;
      if (pd_valid && pd_ready) begin
        chk("R7 beat order", pd_data, PD_W'(pd_exp));
        chk("R9 offset", pd_offset, OFF_W'((jb / CB) * CBYTES));
        chk("R7 last flag", pd_last, (jb == TOTAL - 1));
        chk("R8 no chunk start while read pending", ((jb % CB) == 0) && rd_pend_tb, 0);
        if ((jb % CB) != 0 && rd_pend_tb) midpend++;
        took = 1'b1;
        pd_exp++;
        if (jb == TOTAL - 1) begin jb = 0; jobs_done++; end
        else jb++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    bad_map[5] = 1'b1; bad_map[9] = 1'b1; bad_map[20] = 1'b1;
    rm_valid = 4'b0111;
    rm_from[0*6 +: 6] = 6'd5;  rm_to[0*6 +: 6] = 6'd60;
    rm_from[1*6 +: 6] = 6'd9;  rm_to[1*6 +: 6] = 6'd61;
    rm_from[2*6 +: 6] = 6'd5;  rm_to[2*6 +: 6] = 6'd62;
    rm_from[3*6 +: 6] = 6'd20; rm_to[3*6 +: 6] = 6'd63;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pi_valid = 1'b1;
    #1;
    chk("R10 reset req_ready", req_ready, 1);
    chk("R10 reset cmd valid", ch_cmd_valid, 0);
    chk("R10 reset cpl/pd valid", {cpl_valid, pd_valid, pg_active}, 0);
    // directed pair, remap and error corners
    do_read(16'h0000, 6'd3, 6'd4, 1'b0);
    do_read(16'h0007, 6'd5, 6'd9, 1'b1);
    do_read(16'h0012, 6'd20, 6'd2, 1'b0);
    do_read(16'h0021, 6'd1, 6'd20, 1'b1);
    @(negedge clk);
    #1 chk("R7 no beats without a job", pd_valid, 0);
    @(negedge clk); pg_start = 1'b1;
    @(negedge clk); pg_start = 1'b0;
    #1 chk("R7 job started", pg_active, 1);
    repeat (5) @(negedge clk);
    pg_start = 1'b1;
    @(negedge clk); pg_start = 1'b0;
    // random reads overlapping program jobs
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (!pg_active) begin
        pg_start = 1'b1;
        @(negedge clk); pg_start = 1'b0;
      end
      do_read(16'($urandom), pick_pba(), pick_pba(), 1'($urandom));
      repeat (2) @(negedge clk);
    end
    for (int w = 0; w < 400 && pg_active; w++) @(negedge clk);
    #1 chk("R7 job completes after reads", pg_active, 0);
    chk("R7 at least one full job", jobs_done > 0, 1);
    chk("R8 beats inside a chunk flow during reads", midpend > 0, 1);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule